// File: doc/BRIEF.md
# Bus Termination Decision Logic

This block works out which terminators a parallel SCSI adapter should switch on. It takes three connector-presence flags, four detected terminator enables (secondary and primary, low and high byte), stored configuration bits and chip feature straps. From these it produces an 8-bit board-control byte, a low-byte terminator-power enable, and a flag for an illegal cabling arrangement. Reading the inputs from the board and reporting results are handled elsewhere.

A one-cycle `start` pulse samples all inputs. On the next clock edge the results are registered and `done` pulses for one cycle. The outputs then hold their values until the next `start`. The decision follows one of two paths. The automatic path is taken when the auto-term configuration bit or the new-termination-control strap is set. It uses a connector-count rule, an override for an illegal arrangement, and per-group manual overrides. Otherwise the manual path copies the stored manual bits straight to the outputs.

Top module: `bus_term_resolver`

## Requirements
- R1: While reset is asserted, `board_byte`, `lo_tpwr_en`, `illegal` and `done` are all 0.
- R2: On the automatic path of a chip without `feat_u2`, if all three conditioned presence flags are 1, then `illegal` is 1 and all three presence flags are treated as 0 for the rest of the decision. `illegal` is 0 on ultra2 chips and on the manual path.
- R3: On the automatic path, `board_byte[6]` is 1 when `feat_wide` is 1 and any of these holds: the external cable is absent, the internal wide cable is absent, or the secondary-high enable is set.
- R4: On the automatic path, low-byte termination is wanted when fewer than two conditioned connectors are present or the secondary-low enable is set. On ultra2 chips this sets `board_byte[5]`. Otherwise it sets `lo_tpwr_en`.
- R5: On the automatic path, a set primary-low enable forces `lo_tpwr_en` to 1, and a set primary-high enable sets `board_byte[4]`.
- R6: With `feat_newctl` set, clearing `cfg_se_auto` replaces the secondary low and high enables with `cfg_se_man_lo` and `cfg_se_man_hi`. Clearing `cfg_auto` replaces the primary low and high enables with `cfg_man_lo` and `cfg_man_hi`.
- R7: With `feat_newctl` set, the presence flags are forced to narrow=0, wide=1, external=1 whatever the inputs say. Without `feat_newctl`, the four `det_*` inputs are ignored and act as 0.
- R8: `feat_split50` forces narrow presence to 0. A chip without `feat_wide` has wide presence forced to 0, and `board_byte[6]` is never 1 on such a chip.
- R9: When neither `cfg_auto` nor `feat_newctl` is set, `lo_tpwr_en` equals `cfg_man_lo`, and `board_byte[6]` equals `cfg_man_hi` AND `feat_wide`.
- R10: `done` is 1 exactly one cycle after a `start` pulse and is 0 at all other times. Between start pulses, all result outputs hold their values.
- R11: Bits 7 and 3 to 0 of `board_byte` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to sample inputs and decide |
| has_int_narrow | input | 1 | Internal narrow cable present |
| has_int_wide | input | 1 | Internal wide cable present |
| has_ext | input | 1 | External cable present |
| det_sec_lo | input | 1 | Detected secondary low-byte enable |
| det_sec_hi | input | 1 | Detected secondary high-byte enable |
| det_pri_lo | input | 1 | Detected primary low-byte enable |
| det_pri_hi | input | 1 | Detected primary high-byte enable |
| cfg_auto | input | 1 | Automatic termination selected |
| cfg_se_auto | input | 1 | Automatic single-ended termination selected |
| cfg_man_lo | input | 1 | Manual low-byte (narrow) termination |
| cfg_man_hi | input | 1 | Manual high-byte (wide) termination |
| cfg_se_man_lo | input | 1 | Manual single-ended low termination |
| cfg_se_man_hi | input | 1 | Manual single-ended high termination |
| feat_wide | input | 1 | Chip has a wide bus |
| feat_u2 | input | 1 | Chip belongs to the ultra2 family |
| feat_newctl | input | 1 | Chip uses the newer termination control |
| feat_split50 | input | 1 | 50-pin connector is a separate bus |
| board_byte | output | 8 | Board-control termination byte |
| lo_tpwr_en | output | 1 | Low-byte terminator-power enable |
| illegal | output | 1 | Illegal three-connector arrangement seen |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
The hardest situation to reach is the illegal-arrangement override. It needs the automatic path, a chip that is not ultra2, a wide chip, no separate 50-pin bus, no new termination control, and all three cables present, all at once. Uniform random inputs hit that combination only about once in a few hundred draws. So the stimulus drives it directly, and also drives its near neighbours, each differing by one strap (ultra2, split 50-pin, narrow chip), to show the override stays off. The random phase then biases `feat_newctl` low so that the connector-count table is actually exercised, rather than masked by the forced presence values.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

   // Conditioned connector presence
   typedef struct packed {
      logic narrow;
      logic wide;
      logic ext;
   } presence_t;

   // Terminator group enables after override selection
   typedef struct packed {
      logic sec_lo;
      logic sec_hi;
      logic pri_lo;
      logic pri_hi;
   } group_en_t;

   // Stored configuration bits
   typedef struct packed {
      logic auto_t;
      logic se_auto;
      logic man_lo;
      logic man_hi;
      logic se_man_lo;
      logic se_man_hi;
   } cfg_t;

   // Chip feature straps
   typedef struct packed {
      logic wide;
      logic u2;
      logic newctl;
      logic split50;
   } feat_t;

   typedef struct packed {
      logic [7:0] byte_v;
      logic       tpwr;
      logic       illegal;
   } result_t;

endpackage

// File: rtl/term_presence_cond.sv
module term_presence_cond
   import bus_term_pkg::*;
#(
   parameter bit ILLEGAL_CHECK = 1'b1
) (
   input  presence_t raw_i,
   input  logic      auto_path_i,
   input  logic      wide_i,
   input  logic      u2_i,
   input  logic      newctl_i,
   input  logic      split50_i,
   output presence_t cond_o,
   output logic      illegal_o
);

   presence_t stage_nc;
   presence_t stage_ft;
   logic      all_three;

   // New-control boards report a fixed arrangement for the table
   always_comb begin
      if (newctl_i) begin
         stage_nc.narrow = 1'b0;
         stage_nc.wide   = 1'b1;
         stage_nc.ext    = 1'b1;
      end else begin
         stage_nc = raw_i;
      end
   end

   // Feature straps remove connectors that cannot exist
   always_comb begin
      stage_ft        = stage_nc;
      stage_ft.wide   = stage_nc.wide & wide_i;
      stage_ft.narrow = stage_nc.narrow & ~split50_i;
   end

   assign all_three = stage_ft.narrow & stage_ft.wide & stage_ft.ext;

   generate
      if (ILLEGAL_CHECK) begin : g_chk
         assign illegal_o = auto_path_i & ~u2_i & all_three;
      end else begin : g_nochk
         assign illegal_o = 1'b0;
      end
   endgenerate

   // Illegal arrangement: pretend nothing is connected
   assign cond_o = illegal_o ? presence_t'(3'b000) : stage_ft;

endmodule

// File: rtl/term_enable_select.sv
module term_enable_select
   import bus_term_pkg::*;
(
   input  group_en_t det_i,
   input  cfg_t      cfg_i,
   input  logic      newctl_i,
   output group_en_t en_o
);

   group_en_t sec_sel;

   always_comb begin
      sec_sel = group_en_t'(4'b0000);
      if (newctl_i) begin
         sec_sel = det_i;
         if (!cfg_i.se_auto) begin
            sec_sel.sec_lo = cfg_i.se_man_lo;
            sec_sel.sec_hi = cfg_i.se_man_hi;
         end
         if (!cfg_i.auto_t) begin
            sec_sel.pri_lo = cfg_i.man_lo;
            sec_sel.pri_hi = cfg_i.man_hi;
         end
      end
   end

   assign en_o = sec_sel;

endmodule

// File: rtl/term_byte_map.sv
module term_byte_map
   import bus_term_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int HI_BIT     = 6,
   parameter int SEC_LO_BIT = 5,
   parameter int PRI_HI_BIT = 4,
   parameter int MIN_CONN   = 2
) (
   input  logic              auto_path_i,
   input  presence_t         pres_i,
   input  group_en_t         en_i,
   input  logic              wide_i,
   input  logic              u2_i,
   input  logic              man_lo_i,
   input  logic              man_hi_i,
   output logic [BYTE_W-1:0] byte_o,
   output logic              tpwr_o
);

   localparam int CNT_W = $clog2(MIN_CONN + 2);

   logic [CNT_W-1:0] conn_cnt;
   logic             few_conn;
   logic             low_req;
   logic             hi_on;
   logic             lo_bit_on;
   logic             pri_hi_on;

   assign conn_cnt  = CNT_W'(pres_i.narrow) + CNT_W'(pres_i.wide) + CNT_W'(pres_i.ext);
   assign few_conn  = conn_cnt < CNT_W'(MIN_CONN);
   assign low_req   = auto_path_i & (few_conn | en_i.sec_lo);

   always_comb begin
      if (auto_path_i) begin
         hi_on  = wide_i & (~pres_i.ext | ~pres_i.wide | en_i.sec_hi);
         tpwr_o = (low_req & ~u2_i) | en_i.pri_lo;
      end else begin
         hi_on  = wide_i & man_hi_i;
         tpwr_o = man_lo_i;
      end
   end

   assign lo_bit_on = low_req & u2_i;
   assign pri_hi_on = auto_path_i & en_i.pri_hi;

   generate
      for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
         if (b == HI_BIT) begin : g_hi
            assign byte_o[b] = hi_on;
         end else if (b == SEC_LO_BIT) begin : g_lo
            assign byte_o[b] = lo_bit_on;
         end else if (b == PRI_HI_BIT) begin : g_ph
            assign byte_o[b] = pri_hi_on;
         end else begin : g_spare
            assign byte_o[b] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/bus_term_resolver.sv
module bus_term_resolver
   import bus_term_pkg::*;
#(
   parameter int BYTE_W        = 8,
   parameter int HI_BIT        = 6,
   parameter int SEC_LO_BIT    = 5,
   parameter int PRI_HI_BIT    = 4,
   parameter int MIN_CONN      = 2,
   parameter bit ILLEGAL_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              has_int_narrow,
   input  logic              has_int_wide,
   input  logic              has_ext,
   input  logic              det_sec_lo,
   input  logic              det_sec_hi,
   input  logic              det_pri_lo,
   input  logic              det_pri_hi,
   input  logic              cfg_auto,
   input  logic              cfg_se_auto,
   input  logic              cfg_man_lo,
   input  logic              cfg_man_hi,
   input  logic              cfg_se_man_lo,
   input  logic              cfg_se_man_hi,
   input  logic              feat_wide,
   input  logic              feat_u2,
   input  logic              feat_newctl,
   input  logic              feat_split50,
   output logic [BYTE_W-1:0] board_byte,
   output logic              lo_tpwr_en,
   output logic              illegal,
   output logic              done
);

   generate
      if (HI_BIT >= BYTE_W || SEC_LO_BIT >= BYTE_W || PRI_HI_BIT >= BYTE_W) begin : g_bad_pos
         $error("termination bit position outside board byte");
      end
      if (HI_BIT == SEC_LO_BIT || HI_BIT == PRI_HI_BIT || SEC_LO_BIT == PRI_HI_BIT) begin : g_bad_dup
         $error("termination bit positions must differ");
      end
      if (MIN_CONN < 1 || MIN_CONN > 3) begin : g_bad_cnt
         $error("connector threshold out of range");
      end
   endgenerate

   presence_t         raw_pres;
   presence_t         cond_pres;
   group_en_t         det_en;
   group_en_t         sel_en;
   cfg_t              cfg;
   logic              auto_path;
   logic              illegal_nx;
   logic [BYTE_W-1:0] byte_nx;
   logic              tpwr_nx;

   assign raw_pres  = '{narrow: has_int_narrow, wide: has_int_wide, ext: has_ext};
   assign det_en    = '{sec_lo: det_sec_lo, sec_hi: det_sec_hi,
                        pri_lo: det_pri_lo, pri_hi: det_pri_hi};
   assign cfg       = '{auto_t: cfg_auto, se_auto: cfg_se_auto, man_lo: cfg_man_lo,
                        man_hi: cfg_man_hi, se_man_lo: cfg_se_man_lo,
                        se_man_hi: cfg_se_man_hi};
   assign auto_path = cfg_auto | feat_newctl;

   term_presence_cond #(
      .ILLEGAL_CHECK (ILLEGAL_CHECK)
   ) u_pres (
      .raw_i       (raw_pres),
      .auto_path_i (auto_path),
      .wide_i      (feat_wide),
      .u2_i        (feat_u2),
      .newctl_i    (feat_newctl),
      .split50_i   (feat_split50),
      .cond_o      (cond_pres),
      .illegal_o   (illegal_nx)
   );

   term_enable_select u_sel (
      .det_i    (det_en),
      .cfg_i    (cfg),
      .newctl_i (feat_newctl),
      .en_o     (sel_en)
   );

   term_byte_map #(
      .BYTE_W     (BYTE_W),
      .HI_BIT     (HI_BIT),
      .SEC_LO_BIT (SEC_LO_BIT),
      .PRI_HI_BIT (PRI_HI_BIT),
      .MIN_CONN   (MIN_CONN)
   ) u_map (
      .auto_path_i (auto_path),
      .pres_i      (cond_pres),
      .en_i        (sel_en),
      .wide_i      (feat_wide),
      .u2_i        (feat_u2),
      .man_lo_i    (cfg_man_lo),
      .man_hi_i    (cfg_man_hi),
      .byte_o      (byte_nx),
      .tpwr_o      (tpwr_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         board_byte <= '0;
         lo_tpwr_en <= 1'b0;
         illegal    <= 1'b0;
         done       <= 1'b0;
      end else begin
         done <= start;
         if (start) begin
            board_byte <= byte_nx;
            lo_tpwr_en <= tpwr_nx;
            illegal    <= illegal_nx;
         end
      end
   end

endmodule

// File: rtl/bus_term_resolver_chk.sv
module bus_term_resolver_chk #(
   parameter int BYTE_W     = 8,
   parameter int HI_BIT     = 6,
   parameter int SEC_LO_BIT = 5,
   parameter int PRI_HI_BIT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              feat_u2,
   input logic              feat_wide,
   input logic [BYTE_W-1:0] board_byte,
   input logic              lo_tpwr_en,
   input logic              illegal,
   input logic              done
);

   localparam logic [BYTE_W-1:0] USED_MASK =
      (BYTE_W'(1) << HI_BIT) | (BYTE_W'(1) << SEC_LO_BIT) | (BYTE_W'(1) << PRI_HI_BIT);

   p_done_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> done);

   p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> !done);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(board_byte) && $stable(lo_tpwr_en) && $stable(illegal)));

   p_no_illegal_u2_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && feat_u2) |=> !illegal);

   p_illegal_power_r2: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> lo_tpwr_en);

   p_narrow_no_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !feat_wide) |=> !board_byte[HI_BIT]);

   p_spare_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (board_byte & ~USED_MASK) == '0);

endmodule

bind bus_term_resolver bus_term_resolver_chk #(
   .BYTE_W     (BYTE_W),
   .HI_BIT     (HI_BIT),
   .SEC_LO_BIT (SEC_LO_BIT),
   .PRI_HI_BIT (PRI_HI_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .feat_u2    (feat_u2),
   .feat_wide  (feat_wide),
   .board_byte (board_byte),
   .lo_tpwr_en (lo_tpwr_en),
   .illegal    (illegal),
   .done       (done)
);

// File: tb/tb_bus_term_resolver.sv
`timescale 1ns/1ps
module tb_bus_term_resolver;

   // Stimulus vector bit positions
   localparam int I_N   = 0,  I_W   = 1,  I_E   = 2;
   localparam int I_DSL = 3,  I_DSH = 4,  I_DPL = 5,  I_DPH = 6;
   localparam int I_AU  = 7,  I_SEA = 8,  I_ML  = 9,  I_MH  = 10;
   localparam int I_SML = 11, I_SMH = 12;
   localparam int I_FW  = 13, I_FU  = 14, I_FN  = 15, I_FS  = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start;
   logic [16:0] v;
   logic [7:0]  board_byte;
   logic        lo_tpwr_en, illegal, done;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   bus_term_resolver dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .has_int_narrow(v[I_N]), .has_int_wide(v[I_W]), .has_ext(v[I_E]),
      .det_sec_lo(v[I_DSL]), .det_sec_hi(v[I_DSH]),
      .det_pri_lo(v[I_DPL]), .det_pri_hi(v[I_DPH]),
      .cfg_auto(v[I_AU]), .cfg_se_auto(v[I_SEA]),
      .cfg_man_lo(v[I_ML]), .cfg_man_hi(v[I_MH]),
      .cfg_se_man_lo(v[I_SML]), .cfg_se_man_hi(v[I_SMH]),
      .feat_wide(v[I_FW]), .feat_u2(v[I_FU]),
      .feat_newctl(v[I_FN]), .feat_split50(v[I_FS]),
      .board_byte(board_byte), .lo_tpwr_en(lo_tpwr_en),
      .illegal(illegal), .done(done)
   );

   // Reference model: returns {illegal, tpwr, byte}
   function automatic logic [9:0] model(input logic [16:0] s);
      int n, w, e, cnt;
      bit sl, sh, pl, ph, bad, tp;
      logic [7:0] b;
      b = 8'h00; tp = 0; bad = 0;
      if (s[I_AU] || s[I_FN]) begin
         sl = 0; sh = 0; pl = 0; ph = 0;
         if (s[I_FN]) begin
            sl = s[I_SEA] ? s[I_DSL] : s[I_SML];
            sh = s[I_SEA] ? s[I_DSH] : s[I_SMH];
            pl = s[I_AU]  ? s[I_DPL] : s[I_ML];
            ph = s[I_AU]  ? s[I_DPH] : s[I_MH];
            n = 0; w = 1; e = 1;
         end else begin
            n = s[I_N]; w = s[I_W]; e = s[I_E];
         end
         if (!s[I_FW]) w = 0;
         if (s[I_FS])  n = 0;
         if (!s[I_FU] && n == 1 && w == 1 && e == 1) begin
            bad = 1; n = 0; w = 0; e = 0;
         end
         if (s[I_FW] && (e == 0 || w == 0 || sh)) b[6] = 1'b1;
         cnt = n + w + e;
         if (cnt < 2 || sl) begin
            if (s[I_FU]) b[5] = 1'b1; else tp = 1;
         end
         if (pl) tp = 1;
         if (ph) b[4] = 1'b1;
      end else begin
         tp = s[I_ML];
         b[6] = s[I_MH] & s[I_FW];
      end
      return {bad, tp, b};
   endfunction

   task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got ill=%b tpwr=%b byte=%h, expected ill=%b tpwr=%b byte=%h",
                  tag, act[9], act[8], act[7:0], exp[9], exp[8], exp[7:0]);
      end
   endtask

   task automatic chk_bit(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b, expected %b", tag, act, exp);
      end
   endtask

   // Drive at negedge, pulse start, sample at following negedge
   task automatic run(input string tag, input logic [16:0] s);
      @(negedge clk);
      v = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk_bit({tag, " done"}, done, 1'b1);
      chk(tag, {illegal, lo_tpwr_en, board_byte}, model(s));
   endtask

   function automatic logic [16:0] mk(input int bits[$]);
      logic [16:0] r = '0;
      foreach (bits[i]) r[bits[i]] = 1'b1;
      return r;
   endfunction

   initial begin
      int cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [9:0] held;
      v = '0; start = 1'b0; rst_n = 1'b0;
      void'($urandom(32'h7E21));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset", {illegal, lo_tpwr_en, board_byte}, 10'h000);
      chk_bit("R1 reset done", done, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      // R2 illegal triple on non-ultra2 wide chip
      run("R2 illegal", mk('{I_AU, I_FW, I_N, I_W, I_E}));
      chk("R2 illegal exp", {illegal, lo_tpwr_en, board_byte}, 10'h340);
      run("R2 ultra2 no illegal", mk('{I_AU, I_FW, I_FU, I_N, I_W, I_E}));
      chk("R2 ultra2 exp", {illegal, lo_tpwr_en, board_byte}, 10'h000);
      // R3 high byte from missing external cable
      run("R3 ext absent", mk('{I_AU, I_FW, I_N, I_W}));
      chk("R3 ext absent exp", {illegal, lo_tpwr_en, board_byte}, 10'h040);
      // R4 low byte: ultra2 bit5 vs power enable
      run("R4 u2 one conn", mk('{I_AU, I_FW, I_FU, I_E}));
      chk("R4 u2 exp", {illegal, lo_tpwr_en, board_byte}, 10'h060);
      run("R4 non-u2 one conn", mk('{I_AU, I_FW, I_E}));
      chk("R4 non-u2 exp", {illegal, lo_tpwr_en, board_byte}, 10'h140);
      // R5 primary enables
      run("R5 primary", mk('{I_FN, I_AU, I_SEA, I_DPL, I_DPH, I_FW, I_FU}));
      chk("R5 primary exp", {illegal, lo_tpwr_en, board_byte}, 10'h110);
      // R6 manual overrides under new control
      run("R6 overrides", mk('{I_FN, I_SMH, I_SML, I_MH, I_FW, I_FU, I_DPL, I_DSL}));
      chk("R6 overrides exp", {illegal, lo_tpwr_en, board_byte}, 10'h070);
      // R7 forced presence; detected ignored without new control
      run("R7 forced pres", mk('{I_FN, I_AU, I_SEA, I_FW, I_FU}));
      chk("R7 forced exp", {illegal, lo_tpwr_en, board_byte}, 10'h000);
      run("R7 det ignored", mk('{I_AU, I_FW, I_FU, I_N, I_W, I_E, I_DSL, I_DSH, I_DPL, I_DPH}));
      chk("R7 ignored exp", {illegal, lo_tpwr_en, board_byte}, 10'h000);
      // R8 split 50-pin bus and narrow chip
      run("R8 split50", mk('{I_AU, I_FW, I_FS, I_N, I_W, I_E}));
      chk("R8 split50 exp", {illegal, lo_tpwr_en, board_byte}, 10'h000);
      run("R8 narrow chip", mk('{I_AU, I_N, I_W, I_E, I_DSH}));
      chk("R8 narrow exp", {illegal, lo_tpwr_en, board_byte}, 10'h000);
      // R9 manual path
      run("R9 manual wide", mk('{I_ML, I_MH, I_FW, I_DPH}));
      chk("R9 manual wide exp", {illegal, lo_tpwr_en, board_byte}, 10'h140);
      run("R9 manual narrow", mk('{I_ML, I_MH}));
      chk("R9 manual narrow exp", {illegal, lo_tpwr_en, board_byte}, 10'h100);

      // R10 hold between starts, done single pulse
      run("R10 setup", mk('{I_AU, I_FW, I_N, I_W, I_E}));
      held = {illegal, lo_tpwr_en, board_byte};
      @(negedge clk);
      chk_bit("R10 done falls", done, 1'b0);
      v = mk('{I_ML});
      repeat (4) @(negedge clk);
      chk("R10 hold", {illegal, lo_tpwr_en, board_byte}, held);
      chk_bit("R10 no done", done, 1'b0);

      // Random phase covering R2..R9, R11 (spare bits in model are zero)
      for (int i = 0; i < 600; i++) begin
         logic [16:0] s;
         s = 17'($urandom());
         if ($urandom_range(3) != 0) s[I_FN] = 1'b0;
         run("R11 random", s);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule